// File: doc/BRIEF.md
# Core-Local Interrupt Controller with Level/Priority Arbitration

This block collects up to 64 interrupt sources next to one processor core and turns them into a single registered request. The request carries the winning source's ID, its preemption level and a flag that says whether the source wants vectored handling. Each source owns four bytes of register space: pending, enable, attribute and control. Three global registers sit at the bottom of the address space: a configuration byte, a read-only information word and a threshold byte.

Each control byte is left-aligned. Only its top `CTLB` bits are stored, and the unused low bits read as ones. At run time the configuration byte splits the stored bits into a preemption level (the upper part) and a priority (the lower part). Sources can be level triggered, or triggered on a rising or falling edge of an input that passes through a two-flop synchroniser. The core takes an interrupt by pulsing `claim_i` with the source ID, which clears an edge-triggered pending bit.

The register port is a plain byte-wide port. Writes take effect on the clock edge and reads are combinational.

Top module: `lclic_ctrl`

## Requirements
- R1: Source i owns bytes `SRC_BASE + 4*i` to `+3`. Offset +0 is pending (bit 0), +1 is enable (bit 0), +2 is attribute and +3 is control. The unused bits of the pending and enable bytes read as zero.
- R2: In the attribute byte, bit 0 is the vectored flag. Bits [2:1] are the trigger: 0 = level, 1 = rising edge, 2 = falling edge. A write whose trigger field is 3 leaves the trigger unchanged but still updates bit 0. Bits [7:3] read as zero.
- R3: The configuration byte at 0x000 holds nlbits in bits [4:1]. Its other bits read as zero and ignore writes. The threshold byte at 0x008 is a full 8-bit register. The information word at 0x004..0x007 is little-endian and read-only: [12:0] = number of sources, [20:13] = version, [24:21] = `CTLB`.
- R4: An edge-triggered pending bit behaves as follows:
  - It is set on the selected edge of the synchronised input.
  - A software write of bit 0 sets or clears it.
  - A `claim_i` pulse whose ID matches clears it.
  - If an edge arrives in the same cycle as a write or a claim, the edge wins.
- R5: Only the top `CTLB` bits of a control byte are stored. The low `8-CTLB` bits always read as one.
- R6: A level-triggered pending bit follows the synchronised input. Software writes to it and claims of it have no effect.
- R7: Among sources with pending = 1 and enable = 1, the winner is the one with the largest control byte value, which orders by level first and then by priority. Equal values go to the highest source ID.
- R8: The level reported is the winner's control byte with every bit below its top `min(nlbits, CTLB)` bits forced to one. `irq_req_o` is asserted only when this level is strictly greater than the threshold byte.
- R9: All four outputs are registered one cycle after the register state. `irq_vec_o` is the winner's vectored flag. While `irq_req_o` is low, the ID, level and vectored outputs are zero.
- R10: Reads from any unmapped address return zero, including addresses past the last source group. Writes to unmapped addresses change nothing.
- R11: After reset every register is zero except the control bytes, which read back as their low ones only. No request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw interrupt source lines |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| claim_i | input | 1 | One-cycle claim pulse from the core |
| claim_id_i | input | IDW | Source ID being claimed |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | IDW | ID of the winning source |
| irq_lvl_o | output | 8 | Left-aligned level of the winner |
| irq_vec_o | output | 1 | Winner requests vectored handling |

## Verification
A wrong pending bit, enable bit or control byte changes which ID appears on `irq_id_o` one cycle after the faulty state exists. It also shows directly on `bus_rdata_o` as soon as that register is addressed. A mis-split level boundary or a bad threshold compare shows at the same cycle as a wrong `irq_lvl_o` or a missing or extra `irq_req_o`. A broken synchroniser or edge detector shifts the cycle in which a source wins, so the bench compares against a reference model on every clock rather than only at the end of each pattern.

// File: rtl/lclic_pkg.sv
package lclic_pkg;

    typedef enum logic [1:0] {
        TRG_LEVEL = 2'd0,
        TRG_RISE  = 2'd1,
        TRG_FALL  = 2'd2,
        TRG_RSVD  = 2'd3
    } trig_e;

    localparam int GLB_CFG  = 0;
    localparam int GLB_INFO = 4;
    localparam int GLB_THR  = 8;

endpackage

// File: rtl/lclic_sync.sv
module lclic_sync #(
    parameter int NSRC = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o
);

    typedef struct packed {
        logic [NSRC-1:0] s1;
        logic [NSRC-1:0] s2;
        logic [NSRC-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1   = src_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.s2;
    assign rise_o = sync_q.s2 & ~sync_q.prev;
    assign fall_o = ~sync_q.s2 & sync_q.prev;

endmodule

// File: rtl/lclic_regs.sv
module lclic_regs
    import lclic_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int CTLB     = 4,
    parameter int VERSION  = 1,
    parameter int ADDR_W   = 12,
    parameter int SRC_BASE = 1024,
    localparam int IDW     = $clog2(NSRC)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      wr_i,
    input  logic [7:0]                wdata_i,
    output logic [7:0]                rdata_o,
    input  logic                      claim_i,
    input  logic [IDW-1:0]            claim_id_i,
    input  logic [NSRC-1:0]           lvl_i,
    input  logic [NSRC-1:0]           rise_i,
    input  logic [NSRC-1:0]           fall_i,
    output logic [NSRC-1:0]           ip_o,
    output logic [NSRC-1:0]           ie_o,
    output logic [NSRC-1:0]           vec_o,
    output logic [NSRC-1:0][7:0]      ctl_o,
    output logic [3:0]                nlb_o,
    output logic [7:0]                thr_o
);

    localparam int          LOW     = 8 - CTLB;
    localparam logic [7:0]  LOMASK  = 8'((1 << LOW) - 1);
    localparam int          SRC_END = SRC_BASE + 4 * NSRC;
    localparam logic [31:0] INFO    = {7'b0, 4'(CTLB), 8'(VERSION), 13'(NSRC)};

    typedef struct packed {
        logic [NSRC-1:0]           ip;
        logic [NSRC-1:0]           ie;
        logic [NSRC-1:0]           vec;
        logic [NSRC-1:0][1:0]      trg;
        logic [NSRC-1:0][CTLB-1:0] ctl;
        logic [3:0]                nlb;
        logic [7:0]                thr;
    } reg_t;

    reg_t r_d, r_q;

    logic              src_hit;
    logic              cfg_hit;
    logic              thr_hit;
    logic              info_hit;
    logic [ADDR_W-1:0] off;
    logic [IDW-1:0]    idx;
    logic [1:0]        bsel;

    assign src_hit  = (int'(addr_i) >= SRC_BASE) && (int'(addr_i) < SRC_END);
    assign cfg_hit  = (int'(addr_i) == GLB_CFG);
    assign thr_hit  = (int'(addr_i) == GLB_THR);
    assign info_hit = (int'(addr_i) >= GLB_INFO) && (int'(addr_i) < GLB_INFO + 4);
    assign off      = addr_i - ADDR_W'(SRC_BASE);
    assign idx      = off[IDW+1:2];
    assign bsel     = off[1:0];

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NSRC; i++) begin
            logic sel;
            sel = wr_i && src_hit && (idx == IDW'(i));
            if (r_q.trg[i] == TRG_LEVEL) begin
                r_d.ip[i] = lvl_i[i];
            end else begin
                if (sel && bsel == 2'd0)                  r_d.ip[i] = wdata_i[0];
                if (claim_i && claim_id_i == IDW'(i))     r_d.ip[i] = 1'b0;
                if ((r_q.trg[i] == TRG_RISE && rise_i[i]) ||
                    (r_q.trg[i] == TRG_FALL && fall_i[i])) r_d.ip[i] = 1'b1;
            end
            if (sel && bsel == 2'd1) r_d.ie[i] = wdata_i[0];
            if (sel && bsel == 2'd2) begin
                r_d.vec[i] = wdata_i[0];
                if (wdata_i[2:1] != TRG_RSVD) r_d.trg[i] = wdata_i[2:1];
            end
            if (sel && bsel == 2'd3) r_d.ctl[i] = wdata_i[7 -: CTLB];
        end
        if (wr_i && cfg_hit) r_d.nlb = wdata_i[4:1];
        if (wr_i && thr_hit) r_d.thr = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            ctl_o[i] = (8'(r_q.ctl[i]) << LOW) | LOMASK;
        end
    end

    assign ip_o  = r_q.ip;
    assign ie_o  = r_q.ie;
    assign vec_o = r_q.vec;
    assign nlb_o = r_q.nlb;
    assign thr_o = r_q.thr;

    always_comb begin
        rdata_o = '0;
        if (src_hit) begin
            case (bsel)
                2'd0:    rdata_o = {7'b0, r_q.ip[idx]};
                2'd1:    rdata_o = {7'b0, r_q.ie[idx]};
                2'd2:    rdata_o = {5'b0, r_q.trg[idx], r_q.vec[idx]};
                default: rdata_o = ctl_o[idx];
            endcase
        end else if (cfg_hit) begin
            rdata_o = {3'b0, r_q.nlb, 1'b0};
        end else if (thr_hit) begin
            rdata_o = r_q.thr;
        end else if (info_hit) begin
            rdata_o = INFO[8*addr_i[1:0] +: 8];
        end
    end

    // R5: the unstored low bits of a control byte always read as one
    a_r5_ctl_low_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_hit && bsel == 2'd3) |-> ((rdata_o & LOMASK) == LOMASK));

    // R3: the reserved configuration bits read as zero
    a_r3_cfg_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_hit |-> (rdata_o[0] == 1'b0 && rdata_o[7:5] == 3'b0));

    // R10: unmapped addresses read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!src_hit && !cfg_hit && !thr_hit && !info_hit) |-> (rdata_o == 8'h00));

    for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
        // R4: an edge-triggered pending bit stays set until a write or a claim touches it
        a_r4_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (r_q.trg[g] != TRG_LEVEL && r_q.ip[g] &&
             !(wr_i && src_hit && idx == IDW'(g) && bsel == 2'd0) &&
             !(claim_i && claim_id_i == IDW'(g))) |=> r_q.ip[g]);
        // R6: a level-triggered pending bit follows the synchronised input
        a_r6_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (r_q.trg[g] == TRG_LEVEL) |=> (r_q.ip[g] == $past(lvl_i[g])));
    end

endmodule

// File: rtl/lclic_arb.sv
module lclic_arb #(
    parameter int NSRC = 8,
    parameter int CTLB = 4,
    localparam int IDW = $clog2(NSRC)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NSRC-1:0]      ip_i,
    input  logic [NSRC-1:0]      ie_i,
    input  logic [NSRC-1:0]      vec_i,
    input  logic [NSRC-1:0][7:0] ctl_i,
    input  logic [3:0]           nlb_i,
    input  logic [7:0]           thr_i,
    output logic                 req_o,
    output logic [IDW-1:0]       id_o,
    output logic [7:0]           lvl_o,
    output logic                 vec_o
);

    typedef struct packed {
        logic           req;
        logic [IDW-1:0] id;
        logic [7:0]     lvl;
        logic           vec;
    } out_t;

    out_t o_d, o_q;

    logic           found;
    logic [7:0]     best_key;
    logic [IDW-1:0] best_id;
    logic [3:0]     nlb_eff;
    logic [7:0]     win_lvl;

    always_comb begin
        found    = 1'b0;
        best_key = '0;
        best_id  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ip_i[i] && ie_i[i] && (!found || ctl_i[i] >= best_key)) begin
                found    = 1'b1;
                best_key = ctl_i[i];
                best_id  = IDW'(i);
            end
        end
        nlb_eff = (nlb_i > 4'(CTLB)) ? 4'(CTLB) : nlb_i;
        win_lvl = best_key | (8'hFF >> nlb_eff);

        o_d = '0;
        if (found && (win_lvl > thr_i)) begin
            o_d.req = 1'b1;
            o_d.id  = best_id;
            o_d.lvl = win_lvl;
            o_d.vec = vec_i[best_id];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign req_o = o_q.req;
    assign id_o  = o_q.id;
    assign lvl_o = o_q.lvl;
    assign vec_o = o_q.vec;

    // R8: a raised request always beats the threshold of the previous cycle
    a_r8_above_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (lvl_o > $past(thr_i)));

    // R7: the reported source was pending and enabled one cycle earlier
    a_r7_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (|($past(ip_i & ie_i) & (NSRC'(1) << id_o))));

    // R9: with no request the side outputs are quiet
    a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_o |-> (id_o == '0 && lvl_o == 8'h00 && !vec_o));

endmodule

// File: rtl/lclic_ctrl.sv
module lclic_ctrl #(
    parameter int NSRC     = 8,
    parameter int CTLB     = 4,
    parameter int VERSION  = 1,
    parameter int ADDR_W   = 12,
    parameter int SRC_BASE = 1024,
    localparam int IDW     = $clog2(NSRC)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              claim_i,
    input  logic [IDW-1:0]    claim_id_i,
    output logic              irq_req_o,
    output logic [IDW-1:0]    irq_id_o,
    output logic [7:0]        irq_lvl_o,
    output logic              irq_vec_o
);

    logic [NSRC-1:0]      s_lvl, s_rise, s_fall;
    logic [NSRC-1:0]      ip, ie, vec;
    logic [NSRC-1:0][7:0] ctl;
    logic [3:0]           nlb;
    logic [7:0]           thr;

    lclic_sync #(.NSRC(NSRC)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .lvl_o  (s_lvl),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    lclic_regs #(
        .NSRC(NSRC), .CTLB(CTLB), .VERSION(VERSION),
        .ADDR_W(ADDR_W), .SRC_BASE(SRC_BASE)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (bus_addr_i),
        .wr_i       (bus_wr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .claim_i    (claim_i),
        .claim_id_i (claim_id_i),
        .lvl_i      (s_lvl),
        .rise_i     (s_rise),
        .fall_i     (s_fall),
        .ip_o       (ip),
        .ie_o       (ie),
        .vec_o      (vec),
        .ctl_o      (ctl),
        .nlb_o      (nlb),
        .thr_o      (thr)
    );

    lclic_arb #(.NSRC(NSRC), .CTLB(CTLB)) u_arb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ip_i   (ip),
        .ie_i   (ie),
        .vec_i  (vec),
        .ctl_i  (ctl),
        .nlb_i  (nlb),
        .thr_i  (thr),
        .req_o  (irq_req_o),
        .id_o   (irq_id_o),
        .lvl_o  (irq_lvl_o),
        .vec_o  (irq_vec_o)
    );

endmodule

// File: tb/lclic_ctrl_test.sv
module lclic_ctrl_test;

    localparam int N      = 8;
    localparam int CB     = 4;
    localparam int VER    = 1;
    localparam int AW     = 12;
    localparam int BASE   = 1024;
    localparam int IW     = $clog2(N);
    localparam int CLK_P  = 10;
    localparam logic [7:0] LOM = 8'h0F;
    localparam logic [31:0] INFO_W = 32'h0080_2008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic [7:0]    wd = '0;
    logic [7:0]    rd;
    logic          claim = 1'b0;
    logic [IW-1:0] cid = '0;
    logic          req;
    logic [IW-1:0] id;
    logic [7:0]    lvl;
    logic          vec;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;

    always #(CLK_P/2) clk = ~clk;

    lclic_ctrl #(.NSRC(N), .CTLB(CB), .VERSION(VER), .ADDR_W(AW), .SRC_BASE(BASE)) uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wd), .bus_rdata_o(rd),
        .claim_i(claim), .claim_id_i(cid),
        .irq_req_o(req), .irq_id_o(id), .irq_lvl_o(lvl), .irq_vec_o(vec)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_s1, m_s2, m_pv, m_ip, m_ie, m_vec;
    logic [1:0]   m_trg [N];
    logic [7:0]   m_ctl [N];
    logic [3:0]   m_nlb;
    logic [7:0]   m_thr;
    logic         m_req;
    int           m_id;
    logic [7:0]   m_lvl;
    logic         m_vo;
    logic         m_live = 1'b0;

    function automatic logic [7:0] m_read(input int a);
        if (a >= BASE && a < BASE + 4*N) begin
            int s = (a - BASE) / 4;
            case ((a - BASE) % 4)
                0: return {7'b0, m_ip[s]};
                1: return {7'b0, m_ie[s]};
                2: return {5'b0, m_trg[s], m_vec[s]};
                default: return m_ctl[s];
            endcase
        end
        if (a == 0) return {3'b0, m_nlb, 1'b0};
        if (a == 8) return m_thr;
        if (a >= 4 && a < 8) return 8'(INFO_W >> (8*(a-4)));
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        int w, bk, ne, s, b;
        logic [7:0] lv;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_pv = '0; m_ip = '0; m_ie = '0; m_vec = '0;
            for (int i = 0; i < N; i++) begin m_trg[i] = 2'd0; m_ctl[i] = LOM; end
            m_nlb = '0; m_thr = '0; m_req = 1'b0; m_id = 0; m_lvl = '0; m_vo = 1'b0;
            m_live = 1'b1;
        end else begin
            w = -1; bk = -1;
            for (int i = 0; i < N; i++)
                if (m_ip[i] && m_ie[i] && int'(m_ctl[i]) >= bk) begin bk = int'(m_ctl[i]); w = i; end
            ne = (int'(m_nlb) > CB) ? CB : int'(m_nlb);
            lv = 8'(bk) | 8'(255 >> ne);
            if (w >= 0 && lv > m_thr) begin
                m_req = 1'b1; m_id = w; m_lvl = lv; m_vo = m_vec[w];
            end else begin
                m_req = 1'b0; m_id = 0; m_lvl = '0; m_vo = 1'b0;
            end
            s = -1; b = 0;
            if (wr && int'(addr) >= BASE && int'(addr) < BASE + 4*N) begin
                s = (int'(addr) - BASE) / 4; b = (int'(addr) - BASE) % 4;
            end
            for (int i = 0; i < N; i++) begin
                if (m_trg[i] == 2'd0) m_ip[i] = m_s2[i];
                else begin
                    if (s == i && b == 0) m_ip[i] = wd[0];
                    if (claim && int'(cid) == i) m_ip[i] = 1'b0;
                    if ((m_trg[i] == 2'd1 && m_s2[i] && !m_pv[i]) ||
                        (m_trg[i] == 2'd2 && !m_s2[i] && m_pv[i])) m_ip[i] = 1'b1;
                end
            end
            if (s >= 0) begin
                if (b == 1) m_ie[s] = wd[0];
                if (b == 2) begin
                    m_vec[s] = wd[0];
                    if (wd[2:1] != 2'd3) m_trg[s] = wd[2:1];
                end
                if (b == 3) m_ctl[s] = (wd & ~LOM) | LOM;
            end
            if (wr && addr == 0) m_nlb = wd[4:1];
            if (wr && addr == 8) m_thr = wd;
            m_pv = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    // every-clock comparison, a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (rst_n && m_live) begin
            chk("R8 req vs model", 32'(req), 32'(m_req));
            chk("R7 id vs model",  32'(id),  32'(m_id));
            chk("R8 lvl vs model", 32'(lvl), 32'(m_lvl));
            chk("R9 vec vs model", 32'(vec), 32'(m_vo));
            chk("R1 rdata vs model", 32'(rd), 32'(m_read(int'(addr))));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errs++;
            $display("FAIL watchdog expired got %0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    task automatic wr_reg(input int a, input logic [7:0] d);
        @(negedge clk); addr = AW'(a); wd = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
        @(negedge clk); addr = AW'(a);
        #1 chk(tag, 32'(rd), 32'(exp));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic out_chk(input string tag, input logic r, input int i, input logic [7:0] l, input logic v);
        chk({tag, " req"}, 32'(req), 32'(r));
        chk({tag, " id"},  32'(id),  32'(i));
        chk({tag, " lvl"}, 32'(lvl), 32'(l));
        chk({tag, " vec"}, 32'(vec), 32'(v));
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R11 reset state
        rd_chk("R11 cfg reset", 0, 8'h00);
        rd_chk("R11 thr reset", 8, 8'h00);
        rd_chk("R11 ctl reset", BASE + 3, 8'h0F);
        rd_chk("R11 enable reset", BASE + 1, 8'h00);
        out_chk("R11 no request", 1'b0, 0, 8'h00, 1'b0);
        // R3 info word and configuration byte
        rd_chk("R3 info b0", 4, 8'h08);
        rd_chk("R3 info b1", 5, 8'h20);
        rd_chk("R3 info b2", 6, 8'h80);
        rd_chk("R3 info b3", 7, 8'h00);
        wr_reg(5, 8'hFF);
        rd_chk("R3 info write ignored", 5, 8'h20);
        wr_reg(0, 8'hFF);
        rd_chk("R3 cfg reserved", 0, 8'h1E);
        wr_reg(0, 8'h04);
        rd_chk("R3 cfg nlbits 2", 0, 8'h04);
        // R5 control byte low ones
        wr_reg(BASE + 15, 8'hA5);
        rd_chk("R5 ctl src3", BASE + 15, 8'hAF);
        // R10 unmapped space
        wr_reg(BASE + 35, 8'hFF);
        rd_chk("R10 past last group", BASE + 35, 8'h00);
        rd_chk("R10 hole", 12, 8'h00);
        // R2 attribute, trigger 3 ignored
        wr_reg(BASE + 6, 8'hFF);
        rd_chk("R2 trg 3 ignored", BASE + 6, 8'h01);
        wr_reg(BASE + 6, 8'h05);
        rd_chk("R2 falling vectored", BASE + 6, 8'h05);
        // R6 level source 2
        wr_reg(BASE + 10, 8'h00);
        wr_reg(BASE + 11, 8'h40);
        wr_reg(BASE + 9, 8'h01);
        src[2] = 1'b1;
        wait_n(5);
        out_chk("R6 level source wins", 1'b1, 2, 8'h7F, 1'b0);
        wr_reg(BASE + 8, 8'h00);
        rd_chk("R6 write to level pending ignored", BASE + 8, 8'h01);
        // R8 threshold
        wr_reg(8, 8'h7F);
        wait_n(2);
        out_chk("R8 equal threshold masks", 1'b0, 0, 8'h00, 1'b0);
        wr_reg(8, 8'h7E);
        wait_n(2);
        out_chk("R8 below threshold passes", 1'b1, 2, 8'h7F, 1'b0);
        // R7 tie on equal control byte, higher ID wins; R4 rising edge
        wr_reg(BASE + 22, 8'h02);
        wr_reg(BASE + 23, 8'h40);
        wr_reg(BASE + 21, 8'h01);
        src[5] = 1'b1;
        wait_n(5);
        out_chk("R7 tie to higher id", 1'b1, 5, 8'h7F, 1'b0);
        src[5] = 1'b0;
        wait_n(5);
        rd_chk("R4 edge pending held", BASE + 20, 8'h01);
        // R4 claim clears
        @(negedge clk); claim = 1'b1; cid = IW'(5);
        @(negedge clk); claim = 1'b0; cid = '0;
        wait_n(2);
        out_chk("R4 claim clears", 1'b1, 2, 8'h7F, 1'b0);
        rd_chk("R4 pending after claim", BASE + 20, 8'h00);
        wr_reg(BASE + 20, 8'h01);
        wait_n(2);
        chk("R4 software set", 32'(id), 32'(5));
        wr_reg(BASE + 20, 8'h00);
        wait_n(2);
        chk("R4 software clear", 32'(id), 32'(2));
        // R4 falling edge on source 1, higher level, vectored
        wr_reg(BASE + 7, 8'hC0);
        wr_reg(BASE + 5, 8'h01);
        src[1] = 1'b1;
        wait_n(5);
        chk("R4 no fall yet", 32'(id), 32'(2));
        src[1] = 1'b0;
        wait_n(5);
        out_chk("R9 falling vectored winner", 1'b1, 1, 8'hFF, 1'b1);
        // R8 level split
        wr_reg(0, 8'h08);
        wait_n(2);
        chk("R8 nlbits 4 level", 32'(lvl), 32'(8'hCF));
        wr_reg(0, 8'h10);
        wait_n(2);
        chk("R8 nlbits clamp", 32'(lvl), 32'(8'hCF));
        wr_reg(0, 8'h00);
        wait_n(2);
        chk("R8 nlbits 0 level", 32'(lvl), 32'(8'hFF));
        wr_reg(8, 8'hFF);
        wait_n(2);
        out_chk("R8 top threshold masks all", 1'b0, 0, 8'h00, 1'b0);
        wait_n(2);
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule